// File: doc/BRIEF.md
# Supervisory Watchdog with Ordered Reset Output

This block is a watchdog timer that can run as a standalone supervisor next to a power sequencer. It stays idle until both the supply-good and boot-complete indications are high. It can then wait through an optional startup delay, selected by a 3-bit code, before timeout supervision begins. Software keeps it alive with a single-cycle kick strobe. A 2-bit field picks one of four timeout lengths.

When the timeout elapses, the active-low watchdog output `wdo_n` asserts. With the reset-output enable clear, nothing else happens: `wdo_n` stays low until the next kick. With the enable set, the block runs an ordered sequence. `wdo_n` falls first, `reset_n` falls one cycle later, and `wdo_n` is released after a pulse of about one microsecond. That pulse is counted in clock cycles derived from the clock frequency parameter. `reset_n` is held for a fixed number of cycles. After it releases, the watchdog goes back through its startup delay.

A mode bit sets how the block treats a reset request from the sequencer state machine. In independent mode the request is ignored. Otherwise the request returns the watchdog to its idle state.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters its idle state with `wdo_n` = 1 and `reset_n` = 1.
- R2: The block leaves idle only at an edge where `power_ok` and `boot_done` are both 1. With either one low, both outputs stay high however long the block waits.
- R3: With `start_code` = 000, no startup delay is inserted. `wdo_n` falls T cycles after the edge that samples arming, where T = TMO_BASE * 2^`tmo_sel`, so `tmo_sel` values 0..3 give 1x, 2x, 4x and 8x TMO_BASE.
- R4: With a nonzero `start_code` c, a startup delay of D = c * DLY_UNIT cycles runs first, and `wdo_n` falls D + T cycles after the arming edge. A kick sampled during the delay, including the last delay edge, has no effect.
- R5: A kick sampled while the timeout runs reloads it, so `wdo_n` falls T cycles after the edge that samples the kick.
- R6: With `rst_out_en` = 0 at expiry, `wdo_n` falls and `reset_n` stays 1. `wdo_n` stays 0 until a kick. The kick raises `wdo_n` at the edge that samples it and starts a fresh timeout of T cycles.
- R7: With `rst_out_en` = 1 at expiry, `reset_n` falls exactly one cycle after `wdo_n` falls. `wdo_n` stays low for exactly PULSE_CYC = CLK_MHZ * WDO_US cycles (at least 2 and not above RST_HOLD).
- R8: In the reset sequence, `reset_n` stays low for exactly RST_HOLD cycles. After it rises, the startup delay for the current `start_code` runs again, and `wdo_n` next falls D + T cycles after `reset_n` rises.
- R9: With `indep_mode` = 1, `seq_rst_req` has no effect on timing, on the watchdog state or on either output.
- R10: With `indep_mode` = 0, a sampled `seq_rst_req` returns the block to idle with both outputs high. The block stays idle while the request is held, and it re-arms at the first edge after release at which both arming inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| power_ok | input | 1 | Supply above the lockout threshold |
| boot_done | input | 1 | Boot sequence finished |
| kick | input | 1 | Single-cycle strobe that reloads the timeout |
| indep_mode | input | 1 | 1 = ignore sequencer reset requests |
| rst_out_en | input | 1 | 1 = expiry runs the ordered reset sequence |
| start_code | input | 3 | Startup delay select, 000 = none |
| tmo_sel | input | 2 | Timeout length select |
| seq_rst_req | input | 1 | Reset request from the sequencer state machine |
| wdo_n | output | 1 | Active-low watchdog output, registered |
| reset_n | output | 1 | Active-low system reset output, registered |

## Verification
The arming latency is measured across random combinations of delay code, timeout select and reset enable. The result must match D + T, which separates the delay table from the timeout table and shows that the zero code bypasses the delay. Kicks are placed on the last delay edge and on the first running edge, which shows where kicks stop being ignored. The reset sequence is traced cycle by cycle to check the ordering of the outputs, the pulse width, the hold length and the restart through the delay. A sequencer request is given in both modes, while the timeout runs and after expiry, to show that it clears the watchdog only when independent mode is off.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DELAY   = 3'd1,
    ST_RUN     = 3'd2,
    ST_EXPIRED = 3'd3,
    ST_WARN    = 3'd4,
    ST_HOLD    = 3'd5
  } wdg_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/wdg_period_sel.sv
`timescale 1ns/1ps
// Maps the delay code and timeout select onto counter reload values (length - 1).
module wdg_period_sel #(
  parameter int CNT_W     = 24,
  parameter int TMO_BASE  = 50_000,
  parameter int DLY_UNIT  = 500_000
) (
  input  logic [2:0]       start_code,
  input  logic [1:0]       tmo_sel,
  output logic [CNT_W-1:0] dly_ld,
  output logic [CNT_W-1:0] tmo_ld
);
  logic [CNT_W-1:0] tmo_tab [4];
  logic [CNT_W-1:0] dly_tab [8];

  for (genvar g = 0; g < 4; g++) begin : g_tmo
    assign tmo_tab[g] = CNT_W'((TMO_BASE << g) - 1);
  end

  for (genvar g = 0; g < 8; g++) begin : g_dly
    if (g == 0) begin : g_none
      assign dly_tab[g] = '0;
    end else begin : g_len
      assign dly_tab[g] = CNT_W'((g * DLY_UNIT) - 1);
    end
  end

  assign tmo_ld = tmo_tab[tmo_sel];
  assign dly_ld = dly_tab[start_code];
endmodule

// File: rtl/wdg_down_counter.sv
`timescale 1ns/1ps
// Loadable down counter that stops at zero.
module wdg_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (dec && !zero)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/wdg_supervisor.sv
`timescale 1ns/1ps
module wdg_supervisor #(
  parameter int CLK_MHZ  = 50,
  parameter int WDO_US   = 1,
  parameter int TMO_BASE = 50_000,
  parameter int DLY_UNIT = 500_000,
  parameter int RST_HOLD = 10_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       power_ok,
  input  logic       boot_done,
  input  logic       kick,
  input  logic       indep_mode,
  input  logic       rst_out_en,
  input  logic [2:0] start_code,
  input  logic [1:0] tmo_sel,
  input  logic       seq_rst_req,
  output logic       wdo_n,
  output logic       reset_n
);
  import wdg_pkg::*;

  localparam int PULSE_CYC = CLK_MHZ * WDO_US;
  localparam int MAX_LEN   = max3(TMO_BASE << 3, 7 * DLY_UNIT, RST_HOLD);
  localparam int CNT_W     = $clog2(MAX_LEN + 1) + 1;
  localparam int PUL_W     = $clog2(PULSE_CYC + 1) + 1;
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(RST_HOLD - 1);
  localparam logic [PUL_W-1:0] PULSE_LD = PUL_W'(PULSE_CYC - 1);

  wdg_state_t       st_q, st_nx;
  logic             wdo_q, wdo_nx, rsto_q, rsto_nx;
  logic [CNT_W-1:0] dly_ld, tmo_ld, main_ld;
  logic             main_load, main_dec, main_zero;
  logic             pul_load, pul_dec, pul_zero;
  logic             armed_in, clear_req, start_nodly;

  assign armed_in    = power_ok && boot_done;
  assign clear_req   = seq_rst_req && !indep_mode;
  assign start_nodly = (start_code == 3'd0);

  wdg_period_sel #(
    .CNT_W(CNT_W), .TMO_BASE(TMO_BASE), .DLY_UNIT(DLY_UNIT)
  ) u_sel (
    .start_code(start_code), .tmo_sel(tmo_sel),
    .dly_ld(dly_ld), .tmo_ld(tmo_ld)
  );

  wdg_down_counter #(.CNT_W(CNT_W)) u_main_cnt (
    .clk(clk), .rst(rst), .load(main_load), .load_val(main_ld),
    .dec(main_dec), .zero(main_zero)
  );

  wdg_down_counter #(.CNT_W(PUL_W)) u_pulse_cnt (
    .clk(clk), .rst(rst), .load(pul_load), .load_val(PULSE_LD),
    .dec(pul_dec), .zero(pul_zero)
  );

  always_comb begin
    st_nx     = st_q;
    wdo_nx    = wdo_q;
    rsto_nx   = rsto_q;
    main_load = 1'b0;
    main_ld   = tmo_ld;
    main_dec  = 1'b0;
    pul_load  = 1'b0;
    pul_dec   = 1'b0;

    if (clear_req) begin
      st_nx   = ST_IDLE;
      wdo_nx  = 1'b1;
      rsto_nx = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (armed_in) begin
            main_load = 1'b1;
            if (start_nodly) begin
              st_nx = ST_RUN;
            end else begin
              st_nx   = ST_DELAY;
              main_ld = dly_ld;
            end
          end
        end
        ST_DELAY: begin
          if (main_zero) begin
            st_nx     = ST_RUN;
            main_load = 1'b1;
          end else begin
            main_dec = 1'b1;
          end
        end
        ST_RUN: begin
          if (kick) begin
            main_load = 1'b1;
          end else if (main_zero) begin
            wdo_nx = 1'b0;
            if (rst_out_en) begin
              st_nx    = ST_WARN;
              pul_load = 1'b1;
            end else begin
              st_nx = ST_EXPIRED;
            end
          end else begin
            main_dec = 1'b1;
          end
        end
        ST_EXPIRED: begin
          if (kick) begin
            st_nx     = ST_RUN;
            wdo_nx    = 1'b1;
            main_load = 1'b1;
          end
        end
        ST_WARN: begin
          st_nx     = ST_HOLD;
          rsto_nx   = 1'b0;
          main_load = 1'b1;
          main_ld   = HOLD_LD;
        end
        ST_HOLD: begin
          if (main_zero) begin
            rsto_nx   = 1'b1;
            main_load = 1'b1;
            if (start_nodly) begin
              st_nx = ST_RUN;
            end else begin
              st_nx   = ST_DELAY;
              main_ld = dly_ld;
            end
          end else begin
            main_dec = 1'b1;
          end
        end
        default: st_nx = ST_IDLE;
      endcase

      // Pulse timing of the watchdog output during the reset sequence
      if ((st_q == ST_WARN || st_q == ST_HOLD) && !wdo_q) begin
        if (pul_zero) wdo_nx = 1'b1;
        else          pul_dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wdo_q  <= 1'b1;
      rsto_q <= 1'b1;
    end else begin
      st_q   <= st_nx;
      wdo_q  <= wdo_nx;
      rsto_q <= rsto_nx;
    end
  end

  assign wdo_n   = wdo_q;
  assign reset_n = rsto_q;
endmodule

// File: rtl/wdg_supervisor_chk.sv
`timescale 1ns/1ps
module wdg_supervisor_chk #(
  parameter int RST_HOLD = 10_000
) (
  input logic clk,
  input logic rst,
  input logic kick,
  input logic indep_mode,
  input logic rst_out_en,
  input logic seq_rst_req,
  input logic wdo_n,
  input logic reset_n
);
  localparam int RUN_W = $clog2(RST_HOLD + 1) + 2;
  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || reset_n)            low_run <= '0;
    else if (low_run != '1)        low_run <= low_run + 1'b1;
  end

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (wdo_n && reset_n));

  // R6
  a_r6_no_reset_when_disabled: assert property (@(posedge clk) disable iff (rst)
    ($fell(wdo_n) && !$past(rst_out_en)) |=> reset_n);

  // R7
  a_r7_wdo_leads_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(reset_n) |-> (!wdo_n && !$past(wdo_n)));

  // R7
  a_r7_not_together: assert property (@(posedge clk) disable iff (rst)
    $fell(wdo_n) |-> reset_n);

  // R8
  a_r8_hold_bound: assert property (@(posedge clk) disable iff (rst)
    !reset_n |-> (low_run < RUN_W'(RST_HOLD)));

  // R9
  a_r9_indep_holds: assert property (@(posedge clk) disable iff (rst)
    (!wdo_n && reset_n && !kick && (indep_mode || !seq_rst_req)) |=> !wdo_n);

  // R10
  a_r10_seq_clear: assert property (@(posedge clk) disable iff (rst)
    (seq_rst_req && !indep_mode) |=> (wdo_n && reset_n));
endmodule

bind wdg_supervisor wdg_supervisor_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst(rst), .kick(kick), .indep_mode(indep_mode),
  .rst_out_en(rst_out_en), .seq_rst_req(seq_rst_req),
  .wdo_n(wdo_n), .reset_n(reset_n)
);

// File: tb/tb_wdg_supervisor.sv
`timescale 1ns/1ps
module tb_wdg_supervisor;
  localparam int CLK_MHZ = 50, WDO_US = 1, TMO_B = 32, DLY_U = 8, HOLD = 80;
  localparam int PULSE = CLK_MHZ * WDO_US;
  localparam int LIMIT = 5000;

  logic clk = 1'b0, rst = 1'b1;
  logic power_ok = 0, boot_done = 0, kick = 0, indep_mode = 1, rst_out_en = 0, seq_rst_req = 0;
  logic [2:0] start_code = '0;
  logic [1:0] tmo_sel = '0;
  logic wdo_n, reset_n;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wdg_supervisor #(.CLK_MHZ(CLK_MHZ), .WDO_US(WDO_US), .TMO_BASE(TMO_B),
                   .DLY_UNIT(DLY_U), .RST_HOLD(HOLD)) dut (
    .clk(clk), .rst(rst), .power_ok(power_ok), .boot_done(boot_done), .kick(kick),
    .indep_mode(indep_mode), .rst_out_en(rst_out_en), .start_code(start_code),
    .tmo_sel(tmo_sel), .seq_rst_req(seq_rst_req), .wdo_n(wdo_n), .reset_n(reset_n));

  function automatic int exp_tmo(input logic [1:0] s); return TMO_B << s; endfunction
  function automatic int exp_dly(input logic [2:0] c); return c * DLY_U; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset(input logic [2:0] c, input logic [1:0] s, input logic en, input logic ind);
    @(negedge clk);
    rst = 1; power_ok = 0; boot_done = 0; kick = 0; seq_rst_req = 0;
    start_code = c; tmo_sel = s; rst_out_en = en; indep_mode = ind;
    repeat (3) @(negedge clk);
    rst = 0;
    check(wdo_n && reset_n, "R1", {wdo_n, reset_n}, 3);
  endtask

  // Counts negedges from the current one until wdo_n is seen low.
  task automatic measure_low(input int kick_at, input int req_from, input int req_to, output int n);
    n = 0;
    kick = (kick_at == 0);
    seq_rst_req = (req_from <= 0) && (0 < req_to);
    while (n < LIMIT) begin
      @(negedge clk);
      n++;
      kick = (n == kick_at);
      seq_rst_req = (n >= req_from) && (n < req_to);
      if (!wdo_n) break;
    end
    kick = 0; seq_rst_req = 0;
  endtask

  task automatic arm_and_measure(input int kick_at, input int rf, input int rt, output int n);
    power_ok = 1; boot_done = 1;
    measure_low(kick_at, rf, rt, n);
  endtask

  // Entered at the negedge where wdo_n was first seen low with the reset output enabled.
  task automatic trace_sequence(input int d, input int t);
    int idx = 0, wl = 0, rl = 0, first_r = -1, n;
    bit done = 0;
    check(reset_n == 1, "R7", reset_n, 1);
    while (!done && idx < LIMIT) begin
      if (!wdo_n) wl++;
      if (!reset_n) begin
        rl++;
        if (first_r < 0) first_r = idx;
      end else if (first_r >= 0) done = 1;
      if (!done) begin @(negedge clk); idx++; end
    end
    check(first_r == 1, "R7", first_r, 1);
    check(wl == PULSE, "R7", wl, PULSE);
    check(rl == HOLD, "R8", rl, HOLD);
    measure_low(-1, -1, -1, n);
    check(n == d + t, "R8", n, d + t);
  endtask

  task automatic check_disabled(input int t);
    int n;
    bit bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (wdo_n || !reset_n) bad = 1;
    end
    check(!bad, "R6", bad, 0);
    kick = 1;
    @(negedge clk);
    kick = 0;
    check(wdo_n == 1, "R6", wdo_n, 1);
    measure_low(-1, -1, -1, n);
    check(n == t, "R6", n, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n, t, d;
    bit bad;
    void'($urandom(32'd24680));

    // R1 / R2: idle without both arming inputs
    do_reset(3'd0, 2'd0, 1'b1, 1'b1);
    power_ok = 1; boot_done = 0;
    bad = 0;
    repeat (400) begin @(negedge clk); if (!wdo_n || !reset_n) bad = 1; end
    power_ok = 0; boot_done = 1;
    repeat (400) begin @(negedge clk); if (!wdo_n || !reset_n) bad = 1; end
    check(!bad, "R2", bad, 0);

    // R3: no delay, every timeout select
    for (int s = 0; s < 4; s++) begin
      do_reset(3'd0, 2'(s), 1'b0, 1'b1);
      arm_and_measure(-1, -1, -1, n);
      check(n == exp_tmo(2'(s)) + 1, "R3", n, exp_tmo(2'(s)) + 1);
    end

    // R4: kick on the final delay edge is ignored
    d = exp_dly(3'd5); t = exp_tmo(2'd1);
    do_reset(3'd5, 2'd1, 1'b0, 1'b1);
    arm_and_measure(d, -1, -1, n);
    check(n == d + t + 1, "R4", n, d + t + 1);
    do_reset(3'd5, 2'd1, 1'b0, 1'b1);
    arm_and_measure(10, -1, -1, n);
    check(n == d + t + 1, "R4", n, d + t + 1);

    // R5: first kick in the running phase reloads
    do_reset(3'd5, 2'd1, 1'b0, 1'b1);
    arm_and_measure(d + 1, -1, -1, n);
    check(n == d + t + 2, "R5", n, d + t + 2);
    t = exp_tmo(2'd0);
    do_reset(3'd0, 2'd0, 1'b0, 1'b1);
    arm_and_measure(t - 5, -1, -1, n);
    check(n == 2 * t - 4, "R5", n, 2 * t - 4);

    // R9: independent mode ignores sequencer requests
    do_reset(3'd0, 2'd0, 1'b0, 1'b1);
    arm_and_measure(-1, 5, 20, n);
    check(n == t + 1, "R9", n, t + 1);
    seq_rst_req = 1;
    repeat (3) @(negedge clk);
    seq_rst_req = 0;
    check(wdo_n == 0, "R9", wdo_n, 0);

    // R10: non-independent mode clears and re-arms after release
    do_reset(3'd0, 2'd0, 1'b0, 1'b0);
    arm_and_measure(-1, 10, 20, n);
    check(n == 20 + t + 1, "R10", n, 20 + t + 1);
    seq_rst_req = 1;
    @(negedge clk);
    check(wdo_n && reset_n, "R10", {wdo_n, reset_n}, 3);
    seq_rst_req = 0;

    // Random configurations
    for (int i = 0; i < 18; i++) begin
      logic [2:0] c;
      logic [1:0] s;
      logic en;
      c = 3'($urandom_range(0, 7));
      s = 2'($urandom_range(0, 3));
      en = 1'($urandom_range(0, 1));
      d = exp_dly(c); t = exp_tmo(s);
      do_reset(c, s, en, 1'b1);
      arm_and_measure(-1, -1, -1, n);
      check(n == d + t + 1, (c == 0) ? "R3" : "R4", n, d + t + 1);
      if (en) trace_sequence(d, t);
      else    check_disabled(t);
    end

    summary();
    $finish;
  end
endmodule